// File: doc/BRIEF.md
# Process-window virtual address relocator

This block sits between a processor core and its caches and MMU. It rewrites each core virtual address into a modified virtual address. Any address in the lowest 32 MB is moved into the 32 MB window chosen by a 7-bit process number. Addresses at or above 32 MB pass through untouched. Giving each task its own process number lets several tasks linked at address zero share one translation table without flushing on a context switch.

Relocation applies only when the MMU is on. It is also skipped for addresses that name a single cache or TLB entry during maintenance. The address path is purely combinational.

A small register port writes and reads two registers. One is the process number. The other is a 32-bit context identifier for trace tools; its value drives output pins at all times, and a strobe marks each write to it.

Top module: `pid_remap`

## Requirements
- R1: After reset the process number and context identifier are zero and the context strobe is low, so every address passes through unchanged.
- R2: When the MMU is enabled, the access is not a maintenance access and the address is below 0x0200_0000, the output equals the address plus the process number times 0x0200_0000 (modulo 2^32).
- R3: An address at or above 0x0200_0000 reaches the output unchanged whatever the process number.
- R4: With the MMU disabled the output equals the input address.
- R5: With the maintenance flag set the output equals the input address.
- R6: A write with select 0 stores bits [31:25] of the write data as the process number and ignores bits [24:0]. The new value applies to addresses presented after the write clock edge, and the old value applies before it.
- R7: A read with select 0 returns the process number in bits [31:25] and zero in bits [24:0]. A read with select 1 returns the full context identifier. Read data is combinational.
- R8: A write with select 1 loads all 32 bits into the context identifier, which appears on its output pins from that clock edge. The context strobe is high for exactly the one cycle after each such edge. A process-number write does not raise it.
- R9: A write to either register leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| va_i | input | 32 | Core virtual address |
| mmu_en_i | input | 1 | MMU enabled; relocation allowed |
| maint_i | input | 1 | Entry-based cache or TLB maintenance access |
| mva_o | output | 32 | Modified virtual address |
| reg_we_i | input | 1 | Register write enable |
| reg_sel_i | input | 1 | Register select: 0 process number, 1 context identifier |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the selected register |
| ctx_id_o | output | 32 | Current context identifier |
| ctx_wr_o | output | 1 | One-cycle strobe after a context identifier write |

## Verification
A corrupted process number shows up in the same cycle on the top seven bits of every relocated address. It also shows at once in a select-0 readback, so one read and one low address after each write are enough to find it. A stuck or doubled context strobe is visible in the cycle after the write edge. A context identifier latched from the wrong data is visible on its pins and in the select-1 readback right after that edge.

// File: rtl/pid_remap_pkg.sv
package pid_remap_pkg;
  typedef enum logic {
    SEL_PID = 1'b0,
    SEL_CTX = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/pid_remap_pidreg.sv
module pid_remap_pidreg #(
  parameter int ADDR_W = 32,
  parameter int PID_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [PID_W-1:0]  pid_o
);
  localparam int PID_LSB = ADDR_W - PID_W;

  logic [PID_W-1:0] pid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pid_q <= '0;
    else if (we_i) pid_q <= wdata_i[ADDR_W-1:PID_LSB];
  end

  assign pid_o = pid_q;

  assert_pid_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> pid_q == $past(wdata_i[ADDR_W-1:PID_LSB]));
  assert_pid_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(pid_q));
endmodule

// File: rtl/pid_remap_ctxreg.sv
module pid_remap_ctxreg #(
  parameter int CTX_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTX_W-1:0] wdata_i,
  output logic [CTX_W-1:0] ctx_o,
  output logic             strobe_o
);
  logic [CTX_W-1:0] ctx_q;
  logic             stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_q <= '0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= we_i;
      if (we_i) ctx_q <= wdata_i;
    end
  end

  assign ctx_o    = ctx_q;
  assign strobe_o = stb_q;

  assert_ctx_strobe_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> ctx_q == $past(wdata_i));
  assert_ctx_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_q |-> $stable(ctx_q));
endmodule

// File: rtl/pid_remap_path.sv
module pid_remap_path #(
  parameter int ADDR_W = 32,
  parameter int PID_W  = 7
) (
  input  logic [ADDR_W-1:0] va_i,
  input  logic [PID_W-1:0]  pid_i,
  input  logic              mmu_en_i,
  input  logic              maint_i,
  output logic [ADDR_W-1:0] mva_o
);
  localparam int PID_LSB = ADDR_W - PID_W;

  logic in_low_win;
  logic relocate;

  // Inside the lowest window the top bits are zero, so inserting the PID equals adding it.
  assign in_low_win = (va_i[ADDR_W-1:PID_LSB] == '0);
  assign relocate   = mmu_en_i && !maint_i && in_low_win;
  assign mva_o      = relocate ? {pid_i, va_i[PID_LSB-1:0]} : va_i;
endmodule

// File: rtl/pid_remap.sv
module pid_remap
  import pid_remap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PID_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] va_i,
  input  logic              mmu_en_i,
  input  logic              maint_i,
  output logic [ADDR_W-1:0] mva_o,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic [ADDR_W-1:0] reg_rdata_o,
  output logic [ADDR_W-1:0] ctx_id_o,
  output logic              ctx_wr_o
);
  localparam int PID_LSB = ADDR_W - PID_W;

  logic             pid_we, ctx_we;
  logic [PID_W-1:0] pid;

  assign pid_we = reg_we_i && (reg_sel_e'(reg_sel_i) == SEL_PID);
  assign ctx_we = reg_we_i && (reg_sel_e'(reg_sel_i) == SEL_CTX);

  pid_remap_pidreg #(.ADDR_W(ADDR_W), .PID_W(PID_W)) u_pid (
    .clk_i, .rst_ni, .we_i(pid_we), .wdata_i(reg_wdata_i), .pid_o(pid)
  );

  pid_remap_ctxreg #(.CTX_W(ADDR_W)) u_ctx (
    .clk_i, .rst_ni, .we_i(ctx_we), .wdata_i(reg_wdata_i),
    .ctx_o(ctx_id_o), .strobe_o(ctx_wr_o)
  );

  pid_remap_path #(.ADDR_W(ADDR_W), .PID_W(PID_W)) u_path (
    .va_i, .pid_i(pid), .mmu_en_i, .maint_i, .mva_o
  );

  always_comb begin
    if (reg_sel_e'(reg_sel_i) == SEL_CTX) reg_rdata_o = ctx_id_o;
    else                                  reg_rdata_o = {pid, {PID_LSB{1'b0}}};
  end

  assert_high_passthru_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (va_i[ADDR_W-1:PID_LSB] != '0) |-> mva_o == va_i);
  assert_mmu_off_passthru_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mmu_en_i |-> mva_o == va_i);
  assert_maint_passthru_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    maint_i |-> mva_o == va_i);
  assert_offset_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mva_o[PID_LSB-1:0] == va_i[PID_LSB-1:0]);
  assert_pid_read_low_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_sel_i |-> reg_rdata_o[PID_LSB-1:0] == '0);
  assert_strobe_only_ctx_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pid_we) && !$past(ctx_we) |-> !ctx_wr_o);
endmodule

// File: tb/tb_pid_remap.sv
module tb_pid_remap;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] WIN = 32'h0200_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] va = '0;
  logic        mmu_en = 1'b0;
  logic        maint = 1'b0;
  logic [31:0] mva;
  logic        we = 1'b0;
  logic        sel = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] ctx;
  logic        ctx_wr;

  int checks = 0;
  int errors = 0;
  logic [6:0] exp_pid = '0;
  logic [31:0] exp_ctx = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pid_remap dut (
    .clk_i(clk), .rst_ni(rst_n), .va_i(va), .mmu_en_i(mmu_en), .maint_i(maint),
    .mva_o(mva), .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .ctx_id_o(ctx), .ctx_wr_o(ctx_wr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] a, input logic m, input logic mt,
                                        input logic [6:0] p);
    if (m && !mt && a < WIN) return a + 32'(p) * WIN;
    return a;
  endfunction

  task automatic addr_check(input string req, input logic [31:0] a, input logic m, input logic mt);
    @(negedge clk);
    va = a; mmu_en = m; maint = mt;
    #1 check(req, mva, model(a, m, mt, exp_pid));
  endtask

  task automatic reg_write(input logic s, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = d;
    @(posedge clk);
    #1;
    if (s) begin
      exp_ctx = d;
      check("R8 strobe", {31'b0, ctx_wr}, 32'd1);
      check("R8 ctx pins", ctx, exp_ctx);
    end else begin
      exp_pid = d[31:25];
      check("R8 no strobe on pid write", {31'b0, ctx_wr}, 32'd0);
    end
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic read_check(input string req, input logic s, input logic [31:0] exp);
    @(negedge clk);
    sel = s;
    #1 check(req, rdata, exp);
  endtask

  task automatic t_reset_r1;
    check("R1 ctx", ctx, 32'h0);
    check("R1 strobe", {31'b0, ctx_wr}, 32'h0);
    read_check("R1 pid read", 1'b0, 32'h0);
    addr_check("R1 identity", 32'h0123_4567, 1'b1, 1'b0);
  endtask

  task automatic t_relocate_r2;
    reg_write(1'b0, 32'h0A00_0000); // pid 5
    addr_check("R2 low", 32'h0000_1234, 1'b1, 1'b0);
    addr_check("R2 top of window", 32'h01FF_FFFF, 1'b1, 1'b0);
    addr_check("R2 zero", 32'h0000_0000, 1'b1, 1'b0);
  endtask

  task automatic t_high_r3;
    addr_check("R3 at boundary", 32'h0200_0000, 1'b1, 1'b0);
    addr_check("R3 high", 32'hF000_0010, 1'b1, 1'b0);
  endtask

  task automatic t_bypass_r4_r5;
    addr_check("R4 mmu off", 32'h0000_8000, 1'b0, 1'b0);
    addr_check("R5 maint", 32'h0000_8000, 1'b1, 1'b1);
  endtask

  task automatic t_pid_write_r6;
    // old pid applies before the edge, new pid after it
    @(negedge clk);
    va = 32'h0000_0040; mmu_en = 1'b1; maint = 1'b0;
    we = 1'b1; sel = 1'b0; wdata = 32'hFFFF_FFFF;
    #1 check("R6 old pid before edge", mva, 32'h0A00_0040);
    @(posedge clk);
    #1 check("R6 new pid after edge", mva, 32'hFE00_0040);
    exp_pid = 7'h7F;
    @(negedge clk);
    we = 1'b0;
    read_check("R6 low bits ignored", 1'b0, 32'hFE00_0000);
    addr_check("R6 pid 127", 32'h01FF_FFFF, 1'b1, 1'b0);
    reg_write(1'b0, 32'h01FF_FFFF);
    read_check("R6 only low bits written", 1'b0, 32'h0);
  endtask

  task automatic t_ctx_r7_r8_r9;
    reg_write(1'b0, 32'h0600_0000); // pid 3
    reg_write(1'b1, 32'hDEAD_BEEF);
    @(posedge clk);
    #1 check("R8 strobe one cycle", {31'b0, ctx_wr}, 32'd0);
    read_check("R7 ctx read", 1'b1, 32'hDEAD_BEEF);
    read_check("R9 pid kept after ctx write", 1'b0, 32'h0600_0000);
    addr_check("R9 mapping kept", 32'h0000_0100, 1'b1, 1'b0);
    reg_write(1'b0, 32'h1400_0000);
    read_check("R9 ctx kept after pid write", 1'b1, 32'hDEAD_BEEF);
    read_check("R7 pid read", 1'b0, 32'h1400_0000);
    // back-to-back context writes keep the strobe high
    @(negedge clk);
    we = 1'b1; sel = 1'b1; wdata = 32'h1111_2222;
    @(posedge clk);
    @(negedge clk);
    wdata = 32'h3333_4444;
    @(posedge clk);
    #1 check("R8 back-to-back strobe", {31'b0, ctx_wr}, 32'd1);
    check("R8 second value", ctx, 32'h3333_4444);
    @(negedge clk);
    we = 1'b0;
    @(posedge clk);
    #1 check("R8 strobe drop", {31'b0, ctx_wr}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 2);
    rst_n = 1'b1;
    t_reset_r1();
    t_relocate_r2();
    t_high_r3();
    t_bypass_r4_r5();
    t_pid_write_r6();
    t_ctx_r7_r8_r9();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule